// File: doc/BRIEF.md
# Embedded Controller Host Byte Port

This block is the controller side of a byte-wide mailbox between a host and an embedded controller. The host sees two byte addresses: a data port and a control port. The control port returns status when read and takes a command when written. Each byte the host writes sets an input-full flag. A status bit records whether that byte came through the command path or the data path. The controller takes the byte, acts on it and then clears the input-full flag after a programmable number of cycles. Host software has to poll that flag before it sends the next byte.

Commands start short sequences against a private register space of up to 256 bytes. A read command is followed by one address byte. A write command is followed by an address byte and then a value byte. Results come back through the data port with an output-full flag, and a host read of the data port clears that flag. The burst-on, burst-off and query commands get only a minimal response. Burst-on and burst-off set or clear a burst status bit. Burst-on and query each return a fixed reply byte. A new command that arrives partway through a sequence abandons the old sequence. An unknown command is consumed with no other effect.

Top module: `ec_host_port`

## Requirements
- R1: After reset, reading the control port (offset 4) returns 0x00 and reading the data port (offset 0) returns 0x00.
- R2: A host write to offset 0 or offset 4 while the input-full flag (status bit 1) is clear sets that flag on the next cycle. The flag then stays set for exactly IBF_DELAY+1 cycles and clears by itself.
- R3: Status bit 3 reads 1 when the last accepted byte came through offset 4 (command) and 0 when it came through offset 0 (data).
- R4: A host write made while status bit 1 is set is dropped. It changes no flag, no register and no sequence.
- R5: Command 0x80 followed by an address byte places the value of that register on the data port and sets the output-full flag (status bit 0). Registers read 0x00 until they are written.
- R6: Command 0x81 followed by an address byte and a value byte stores the value in that register. This holds for addresses 0x00 and 0xFF as well.
- R7: A host read of offset 0 clears status bit 0 on the next cycle. A host read of offset 4 leaves it unchanged.
- R8: Command 0x82 sets status bit 4 and returns 0x90 with status bit 0 set. Command 0x83 clears status bit 4 and returns nothing.
- R9: Command 0x84 returns 0x00 on the data port with status bit 0 set.
- R10: A command byte that arrives inside a sequence ends that sequence with no register written, and the new command starts at once.
- R11: An unknown command byte, or a data byte received outside a sequence, is consumed. Its input-full flag clears on schedule, and it produces no output and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host byte offset: 0 is the data port, 4 is the status/command port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; a read of the data port clears output-full |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or data byte, chosen by host_addr |

## Verification
The checker tests the flag rules on every cycle. An accepted write sets input-full. The command/data marker follows the port that was written. A byte written while input-full is set leaves the latched byte unchanged. A produced result raises output-full, and a data-port read with no new result lowers it. The effects that span several bytes can only be shown by the bench scenarios. These are the exact length of the input-full window, the register contents after write and read sequences (including address 0x00 and 0xFF), the burst and query replies, abandoning a sequence partway, and dropping unknown commands and stray data bytes.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;

   localparam logic [7:0] CMD_RD_REG    = 8'h80;
   localparam logic [7:0] CMD_WR_REG    = 8'h81;
   localparam logic [7:0] CMD_BURST_ON  = 8'h82;
   localparam logic [7:0] CMD_BURST_OFF = 8'h83;
   localparam logic [7:0] CMD_QUERY     = 8'h84;

   // status byte bit positions
   localparam int ST_OUT_FULL = 0;
   localparam int ST_IN_FULL  = 1;
   localparam int ST_WAS_CMD  = 3;
   localparam int ST_BURST    = 4;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_RD_ADDR,
      SEQ_WR_ADDR,
      SEQ_WR_DATA
   } seq_state_e;

endpackage

// File: rtl/ec_port_if.sv
module ec_port_if #(
   parameter int ADDR_W   = 3,
   parameter int DATA_OFS = 0,
   parameter int CTRL_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              ibf_clr,
   input  logic              obf_load,
   input  logic [7:0]        obf_byte,
   input  logic              burst,
   output logic              ibf,
   output logic              in_is_cmd,
   output logic [7:0]        in_byte,
   output logic              obf
);
   import ec_port_pkg::*;

   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   logic       sel_data, sel_ctrl, accept;
   logic [7:0] dout_q, status;

   assign sel_data = (host_addr == DATA_A);
   assign sel_ctrl = (host_addr == CTRL_A);
   assign accept   = host_wr && !ibf && (sel_data || sel_ctrl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf       <= 1'b0;
         in_is_cmd <= 1'b0;
         in_byte   <= 8'h00;
      end else if (accept) begin
         ibf       <= 1'b1;
         in_is_cmd <= sel_ctrl;
         in_byte   <= host_wdata;
      end else if (ibf_clr) begin
         ibf       <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obf    <= 1'b0;
         dout_q <= 8'h00;
      end else if (obf_load) begin
         obf    <= 1'b1;
         dout_q <= obf_byte;
      end else if (host_rd && sel_data) begin
         obf    <= 1'b0;
      end
   end

   always_comb begin
      status              = 8'h00;
      status[ST_OUT_FULL] = obf;
      status[ST_IN_FULL]  = ibf;
      status[ST_WAS_CMD]  = in_is_cmd;
      status[ST_BURST]    = burst;
   end

   assign host_rdata = sel_ctrl ? status : (sel_data ? dout_q : 8'h00);

endmodule

// File: rtl/ec_reg_space.sv
module ec_reg_space #(
   parameter int REG_AW    = 8,
   parameter bit MEM_CLEAR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] waddr,
   input  logic [7:0] wdata,
   input  logic [7:0] raddr,
   output logic [7:0] rdata
);
   localparam int DEPTH = 1 << REG_AW;

   logic [7:0]        mem [DEPTH];
   logic [REG_AW-1:0] widx, ridx;

   generate
      if (REG_AW == 8) begin : g_full
         assign widx = waddr;
         assign ridx = raddr;
      end else begin : g_trunc
         assign widx = waddr[REG_AW-1:0];
         assign ridx = raddr[REG_AW-1:0];
      end

      if (MEM_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (we) begin
               mem[widx] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[ridx];

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq #(
   parameter int         IBF_DELAY = 3,
   parameter logic [7:0] BURST_ACK = 8'h90,
   parameter logic [7:0] QUERY_ACK = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ibf,
   input  logic       in_is_cmd,
   input  logic [7:0] in_byte,
   input  logic [7:0] mem_rdata,
   output logic       ibf_clr,
   output logic       obf_load,
   output logic [7:0] obf_byte,
   output logic       burst,
   output logic       mem_we,
   output logic [7:0] mem_waddr,
   output logic [7:0] mem_wdata,
   output logic [7:0] mem_raddr
);
   import ec_port_pkg::*;

   localparam int               CNT_W   = $clog2(IBF_DELAY + 1);
   localparam logic [CNT_W-1:0] DELAY_V = CNT_W'(IBF_DELAY);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       addr_q;
   logic             take, burst_d;

   assign take    = ibf && (cnt_q == '0);
   assign ibf_clr = (cnt_q == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (take)        cnt_q <= DELAY_V;
      else if (cnt_q != '0) cnt_q <= cnt_q - ONE_V;
   end

   always_comb begin
      state_d  = state_q;
      burst_d  = burst;
      obf_load = 1'b0;
      obf_byte = 8'h00;
      mem_we   = 1'b0;
      if (take) begin
         if (in_is_cmd) begin
            state_d = SEQ_IDLE;
            case (in_byte)
               CMD_RD_REG:    state_d = SEQ_RD_ADDR;
               CMD_WR_REG:    state_d = SEQ_WR_ADDR;
               CMD_BURST_ON: begin
                  burst_d  = 1'b1;
                  obf_load = 1'b1;
                  obf_byte = BURST_ACK;
               end
               CMD_BURST_OFF: burst_d = 1'b0;
               CMD_QUERY: begin
                  obf_load = 1'b1;
                  obf_byte = QUERY_ACK;
               end
               default:       state_d = SEQ_IDLE;
            endcase
         end else begin
            case (state_q)
               SEQ_RD_ADDR: begin
                  obf_load = 1'b1;
                  obf_byte = mem_rdata;
                  state_d  = SEQ_IDLE;
               end
               SEQ_WR_ADDR: state_d = SEQ_WR_DATA;
               SEQ_WR_DATA: begin
                  mem_we  = 1'b1;
                  state_d = SEQ_IDLE;
               end
               default:     state_d = SEQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         burst   <= 1'b0;
         addr_q  <= 8'h00;
      end else begin
         state_q <= state_d;
         burst   <= burst_d;
         if (take && !in_is_cmd && state_q == SEQ_WR_ADDR) addr_q <= in_byte;
      end
   end

   assign mem_raddr = in_byte;
   assign mem_waddr = addr_q;
   assign mem_wdata = in_byte;

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
   parameter int         ADDR_W    = 3,
   parameter int         DATA_OFS  = 0,
   parameter int         CTRL_OFS  = 4,
   parameter int         REG_AW    = 8,
   parameter bit         MEM_CLEAR = 1'b1,
   parameter int         IBF_DELAY = 3,
   parameter logic [7:0] BURST_ACK = 8'h90,
   parameter logic [7:0] QUERY_ACK = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata
);
   generate
      if (IBF_DELAY < 1) begin : g_bad_delay
         $error("IBF_DELAY must be at least 1");
      end
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (DATA_OFS == CTRL_OFS) begin : g_bad_ofs
         $error("data and control offsets must differ");
      end
      if (DATA_OFS >= (1 << ADDR_W) || CTRL_OFS >= (1 << ADDR_W)) begin : g_bad_aw2
         $error("offsets must fit in ADDR_W");
      end
   endgenerate

   logic       ibf, in_is_cmd, obf, ibf_clr, obf_load, burst, mem_we;
   logic [7:0] in_byte, obf_byte, mem_waddr, mem_wdata, mem_raddr, mem_rdata;

   ec_port_if #(
      .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
   ) u_if (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ibf_clr(ibf_clr), .obf_load(obf_load), .obf_byte(obf_byte),
      .burst(burst), .ibf(ibf), .in_is_cmd(in_is_cmd),
      .in_byte(in_byte), .obf(obf)
   );

   ec_cmd_seq #(
      .IBF_DELAY(IBF_DELAY), .BURST_ACK(BURST_ACK), .QUERY_ACK(QUERY_ACK)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ibf(ibf), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
      .mem_rdata(mem_rdata), .ibf_clr(ibf_clr), .obf_load(obf_load),
      .obf_byte(obf_byte), .burst(burst), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr)
   );

   ec_reg_space #(
      .REG_AW(REG_AW), .MEM_CLEAR(MEM_CLEAR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
   parameter int ADDR_W   = 3,
   parameter int DATA_OFS = 0,
   parameter int CTRL_OFS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic              ibf,
   input logic              in_is_cmd,
   input logic [7:0]        in_byte,
   input logic              obf,
   input logic              obf_load
);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !ibf && (host_addr == DATA_A || host_addr == CTRL_A)) |=> ibf);

   p_ibf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |=> ibf);

   p_cmd_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !ibf && host_addr == CTRL_A) |=> in_is_cmd);

   p_data_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !ibf && host_addr == DATA_A) |=> !in_is_cmd);

   p_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && ibf) |=> ($stable(in_byte) && $stable(in_is_cmd)));

   p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      obf_load |=> obf);

   p_obf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == DATA_A && !obf_load) |=> !obf);

endmodule

bind ec_host_port ec_host_port_chk #(
   .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
   .host_rd(host_rd), .ibf(ibf), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
   .obf(obf), .obf_load(obf_load)
);

// File: tb/ec_host_port_tb.sv
module ec_host_port_tb;
   localparam int D = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ec_host_port #(.IBF_DELAY(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   task automatic wait_in_free();
      logic [7:0] s;
      for (int i = 0; i < 100; i++) begin
         peek(3'd4, s);
         if (!s[1]) return;
         @(negedge clk);
      end
      checks++; errors++;
      $display("FAIL R2: input-full stuck, actual 1 expected 0");
   endtask

   task automatic raw_write(input logic [2:0] a, input logic [7:0] b);
      host_addr = a; host_wdata = b; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic send(input logic [2:0] a, input logic [7:0] b);
      wait_in_free();
      raw_write(a, b);
   endtask

   task automatic read_data(output logic [7:0] v);
      host_addr = 3'd0; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      peek(3'd4, v); check("R1 status", v, 8'h00);
      peek(3'd0, v); check("R1 data", v, 8'h00);
   endtask

   task automatic t_flag_window();
      logic [7:0] v;
      raw_write(3'd0, 8'h55);
      for (int i = 0; i < D + 1; i++) begin
         peek(3'd4, v); check("R2 in-full held", {7'd0, v[1]}, 8'd1);
         if (i == 0) check("R3 data mark", {7'd0, v[3]}, 8'd0);
         @(negedge clk);
      end
      peek(3'd4, v); check("R2 in-full cleared", {7'd0, v[1]}, 8'd0);
      check("R11 stray data no output", {7'd0, v[0]}, 8'd0);
   endtask

   task automatic t_unknown();
      logic [7:0] v;
      send(3'd4, 8'h11);
      peek(3'd4, v); check("R3 cmd mark", {7'd0, v[3]}, 8'd1);
      wait_in_free();
      peek(3'd4, v); check("R11 unknown cmd status", v, 8'h08);
   endtask

   task automatic t_write(input logic [7:0] a, input logic [7:0] d);
      send(3'd4, 8'h81); send(3'd0, a); send(3'd0, d);
      wait_in_free();
   endtask

   task automatic t_readback(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] v;
      send(3'd4, 8'h80); send(3'd0, a);
      wait_in_free();
      peek(3'd4, v); check({req, " out-full"}, {7'd0, v[0]}, 8'd1);
      read_data(v); check({req, " value"}, v, exp);
   endtask

   task automatic t_busy_drop();
      logic [7:0] v;
      raw_write(3'd4, 8'h80);
      raw_write(3'd0, 8'h07);   // dropped: input-full still set
      peek(3'd4, v); check("R4 mark unchanged", {7'd0, v[3]}, 8'd1);
      wait_in_free();
      peek(3'd4, v); check("R4 no result from dropped byte", {7'd0, v[0]}, 8'd0);
      send(3'd0, 8'h07);
      wait_in_free();
      read_data(v); check("R5 unwritten reads zero", v, 8'h00);
   endtask

   task automatic t_obf_clear();
      logic [7:0] v;
      t_write(8'h3C, 8'hA5);
      send(3'd4, 8'h80); send(3'd0, 8'h3C);
      wait_in_free();
      host_rd = 1'b1; peek(3'd4, v); @(negedge clk); host_rd = 1'b0;
      peek(3'd4, v); check("R7 status read keeps out-full", {7'd0, v[0]}, 8'd1);
      read_data(v); check("R6 value 0x3C", v, 8'hA5);
      peek(3'd4, v); check("R7 data read clears out-full", {7'd0, v[0]}, 8'd0);
   endtask

   task automatic t_burst_query();
      logic [7:0] v;
      send(3'd4, 8'h82); wait_in_free();
      peek(3'd4, v); check("R8 burst bit set", {7'd0, v[4]}, 8'd1);
      check("R8 burst ack out-full", {7'd0, v[0]}, 8'd1);
      read_data(v); check("R8 burst ack byte", v, 8'h90);
      send(3'd4, 8'h83); wait_in_free();
      peek(3'd4, v); check("R8 burst off status", v, 8'h08);
      send(3'd4, 8'h84); wait_in_free();
      peek(3'd4, v); check("R9 query out-full", {7'd0, v[0]}, 8'd1);
      read_data(v); check("R9 query byte", v, 8'h00);
   endtask

   task automatic t_abort();
      t_write(8'h40, 8'h11);
      send(3'd4, 8'h81); send(3'd0, 8'h40);
      t_readback("R10 abort keeps old value", 8'h40, 8'h11);
      send(3'd4, 8'h81); send(3'd0, 8'h50);
      send(3'd4, 8'h99); send(3'd0, 8'h77);
      wait_in_free();
      t_readback("R11 unknown cmd aborts write", 8'h50, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flag_window();
      t_unknown();
      t_busy_drop();
      t_obf_clear();
      t_write(8'h00, 8'h5A);
      t_write(8'hFF, 8'hC3);
      t_readback("R6 addr 0x00", 8'h00, 8'h5A);
      t_readback("R6 addr 0xFF", 8'hFF, 8'hC3);
      t_readback("R5 write did not alias", 8'h3C, 8'hA5);
      t_burst_query();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule